// File: doc/BRIEF.md
# Conversion Start and Power-Mode Sequencer

This block is the digital control core of an 8-bit sampling successive-approximation converter running from a fixed system clock. A single external start input sets everything in motion. A qualified rising edge on that input powers up the analog section and fires an internal power-up pulse of fixed length. The gated start is the OR of the input and that pulse. A conversion begins when the gated start falls, so it begins at whichever of the two falling edges comes later.

While converting, the block holds the track/hold circuit in hold and raises busy. It steps a trial code one bit at a time, from the most significant bit down, and reads back a one-bit comparator decision. At the end it latches the result and returns to track. The level of the start input at that moment picks the power mode. If the input is high, the analog section stays powered and the next falling edge starts at once. If it is low, the block powers down until the next rising edge.

The input is synchronised through two flops. It must stay high for a minimum number of clock cycles before a rising edge is accepted.

Top module: `conv_start_seq`

## Requirements
- R1: After reset, power enable, busy, hold, the internal pulse, the result strobe and the error flag are all low, and the result register reads 0.
- R2: A high level on `start_i` lasting fewer than MIN_HI_CYC clock cycles is ignored. Power stays off and no conversion starts.
- R3: An accepted rising edge sets power enable and holds `pulse_o` high for exactly PWRUP_CYC cycles. `gate_o` is the OR of the filtered start level and `pulse_o`.
- R4: A conversion begins only on a falling edge of `gate_o`. Busy never rises while `start_i` is still held high after the power-up pulse has ended.
- R5: Busy and hold are high together for exactly CONV_CYC cycles per conversion.
- R6: In the cycle busy falls, `result_stb_o` is high for one cycle and `result_o` carries the new code.
- R7: The trial code starts at 0x80 and resolves one bit per CONV_CYC/8 cycles, from bit 7 to bit 0. A bit is kept when `cmp_i` is 1, which means the input is at or above the trial level. Otherwise the bit is cleared. The result is therefore straight binary.
- R8: If the filtered start level is high when the conversion ends, power enable stays high. If the level is low, power enable drops to 0.
- R9: A rising edge while busy is high does not restart the conversion or lengthen it, and it does not fire the power-up pulse. Instead `err_o` pulses for one cycle.
- R10: With power held on, the next falling edge of `start_i` starts a conversion within 8 cycles, without waiting for a power-up pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | External convert-start, asynchronous |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| pwr_en_o | output | 1 | Analog section power enable |
| pulse_o | output | 1 | Internal power-up pulse |
| gate_o | output | 1 | Gated start (start level OR power-up pulse) |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| busy_o | output | 1 | Conversion in progress |
| trial_o | output | CODE_W | Trial code driving the DAC |
| result_o | output | CODE_W | Latched conversion result |
| result_stb_o | output | 1 | One-cycle strobe when the result is latched |
| err_o | output | 1 | One-cycle flag for a start edge seen while busy |

## Verification
The conversion is tried with analog levels 0xA5, 0x00, 0xFF, 0x3C and 0x81 against a model comparator. The two extremes show that every bit is cleared or every bit kept, and the mixed codes show that each bit is decided on its own. Three start patterns separate the modes. A short pulse lets the power-up pulse's falling edge start the conversion. A long high level lets the input's own falling edge start it. A level re-raised during the conversion exercises the error flag, keeps power on, and gives an immediate restart. A start pulse below the minimum width shows the filter rejecting glitches.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
   typedef enum logic {
      SAR_IDLE = 1'b0,
      SAR_RUN  = 1'b1
   } sar_state_e;
endpackage

// File: rtl/start_filter.sv
module start_filter #(
   parameter int MIN_HI_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o,
   output logic rise_o
);
   logic sync1, sync2, lvl_q, lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1 <= 1'b0;
         sync2 <= 1'b0;
      end else begin
         sync1 <= raw_i;
         sync2 <= sync1;
      end
   end

   generate
      if (MIN_HI_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= sync2;
         end
      end else begin : g_counted
         localparam int CNT_W = $clog2(MIN_HI_CYC + 1);
         logic [CNT_W-1:0] hi_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_cnt <= '0;
               lvl_q  <= 1'b0;
            end else if (!sync2) begin
               hi_cnt <= '0;
               lvl_q  <= 1'b0;
            end else if (hi_cnt == CNT_W'(MIN_HI_CYC - 1)) begin
               lvl_q  <= 1'b1;
            end else begin
               hi_cnt <= hi_cnt + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_q;
   end

   assign lvl_o  = lvl_q;
   assign rise_o = lvl_q & ~lvl_d;

   // R2: the filtered level only rises from a synchronised high sample
   p_lvl_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_q) |-> $past(sync2));
endmodule

// File: rtl/pwrup_stretch.sv
module pwrup_stretch #(
   parameter int PWRUP_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   localparam int CNT_W = $clog2(PWRUP_CYC + 1);
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left <= '0;
      else if (fire_i)       left <= CNT_W'(PWRUP_CYC);
      else if (left != '0)   left <= left - 1'b1;
   end

   assign pulse_o = (left != '0);

   // R3: a fire request always produces a high pulse on the next cycle
   p_fire_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> pulse_o);
endmodule

// File: rtl/sar_core.sv
module sar_core
   import conv_seq_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int CONV_CYC = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              cmp_i,
   output logic              busy_o,
   output logic [CODE_W-1:0] trial_o,
   output logic [CODE_W-1:0] result_o,
   output logic              done_o
);
   localparam int STEP   = CONV_CYC / CODE_W;
   localparam int STEP_W = $clog2(STEP + 1);
   localparam int IDX_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1;
   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   sar_state_e        state;
   logic [STEP_W-1:0] step;
   logic [IDX_W-1:0]  idx;
   logic [CODE_W-1:0] trial, kept;
   logic              step_end;

   always_comb begin
      step_end = (step == STEP_W'(STEP - 1));
      kept     = cmp_i ? trial : (trial & ~(ONE << idx));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SAR_IDLE;
         step     <= '0;
         idx      <= '0;
         trial    <= '0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (state == SAR_IDLE) begin
            if (go_i) begin
               state <= SAR_RUN;
               step  <= '0;
               idx   <= IDX_W'(CODE_W - 1);
               trial <= ONE << (CODE_W - 1);
            end
         end else if (step_end) begin
            step <= '0;
            if (idx == '0) begin
               state    <= SAR_IDLE;
               trial    <= kept;
               result_o <= kept;
               done_o   <= 1'b1;
            end else begin
               trial <= kept | (ONE << (idx - 1'b1));
               idx   <= idx - 1'b1;
            end
         end else begin
            step <= step + 1'b1;
         end
      end
   end

   assign busy_o  = (state == SAR_RUN);
   assign trial_o = trial;

   // R7: during a conversion the bit under test is always set in the trial code
   p_trial_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> trial[idx]);
   // R6: the done strobe lasts a single cycle
   p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
   parameter int CODE_W     = 8,
   parameter int PWRUP_CYC  = 20,
   parameter int CONV_CYC   = 48,
   parameter int MIN_HI_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cmp_i,
   output logic              pwr_en_o,
   output logic              pulse_o,
   output logic              gate_o,
   output logic              hold_o,
   output logic              busy_o,
   output logic [CODE_W-1:0] trial_o,
   output logic [CODE_W-1:0] result_o,
   output logic              result_stb_o,
   output logic              err_o
);
   generate
      if (CODE_W < 1)                begin : g_bad_w    $error("CODE_W must be positive"); end
      if (PWRUP_CYC < 1)             begin : g_bad_pu   $error("PWRUP_CYC must be positive"); end
      if (MIN_HI_CYC < 1)            begin : g_bad_hi   $error("MIN_HI_CYC must be positive"); end
      if (CONV_CYC < CODE_W)         begin : g_bad_cv   $error("CONV_CYC below CODE_W"); end
      if (CONV_CYC % CODE_W != 0)    begin : g_bad_div  $error("CONV_CYC must divide by CODE_W"); end
   endgenerate

   logic lvl, rise, accept, pulse, gate, gate_d, go, done, busy, pwr_q, err_q;

   start_filter #(.MIN_HI_CYC(MIN_HI_CYC)) u_filter (
      .clk(clk), .rst_n(rst_n), .raw_i(start_i), .lvl_o(lvl), .rise_o(rise));

   assign accept = rise & ~busy;

   pwrup_stretch #(.PWRUP_CYC(PWRUP_CYC)) u_stretch (
      .clk(clk), .rst_n(rst_n), .fire_i(accept), .pulse_o(pulse));

   assign gate = lvl | pulse;
   assign go   = gate_d & ~gate & pwr_q & ~busy;

   sar_core #(.CODE_W(CODE_W), .CONV_CYC(CONV_CYC)) u_sar (
      .clk(clk), .rst_n(rst_n), .go_i(go), .cmp_i(cmp_i), .busy_o(busy),
      .trial_o(trial_o), .result_o(result_o), .done_o(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         pwr_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         gate_d <= gate;
         err_q  <= rise & busy;
         if (accept || go) pwr_q <= 1'b1;
         else if (done)    pwr_q <= lvl;
      end
   end

   assign pwr_en_o     = pwr_q;
   assign pulse_o      = pulse;
   assign gate_o       = gate;
   assign hold_o       = busy;
   assign busy_o       = busy;
   assign result_stb_o = done;
   assign err_o        = err_q;

   // R4: busy rises only after the gated start was low
   p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(gate_o));
   // R3: no conversion starts while the power-up pulse is running
   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(pulse_o));
   // R8: the analog section is powered throughout a conversion
   p_pwr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> pwr_en_o);
   // R6: end of busy comes with the result strobe
   p_stb_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> result_stb_o);
   // R9: an error flag only follows a busy cycle
   p_err_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(busy_o));
endmodule

// File: tb/conv_start_seq_bench.sv
module conv_start_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 8;
   localparam int PWRUP_CYC  = 20;
   localparam int CONV_CYC   = 48;
   localparam int MIN_HI_CYC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CODE_W-1:0] vin = '0;
   logic cmp_i;
   logic pwr_en_o, pulse_o, gate_o, hold_o, busy_o, result_stb_o, err_o;
   logic [CODE_W-1:0] trial_o, result_o;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign cmp_i = (vin >= trial_o);

   conv_start_seq #(.CODE_W(CODE_W), .PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC),
                    .MIN_HI_CYC(MIN_HI_CYC)) u_conv_start_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .pwr_en_o(pwr_en_o), .pulse_o(pulse_o), .gate_o(gate_o), .hold_o(hold_o),
      .busy_o(busy_o), .trial_o(trial_o), .result_o(result_o),
      .result_stb_o(result_stb_o), .err_o(err_o));

   int n_chk = 0, n_bad = 0;
   int busy_rises = 0, err_seen = 0, width = 0;
   logic busy_prev = 1'b0;
   logic [CODE_W-1:0] exp_q[$];
   bit done_flag = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) if (rst_n) begin
      if (err_o) err_seen++;
      if (busy_o && !busy_prev) begin busy_rises++; width = 1; end
      else if (busy_o) width++;
      if (busy_o) chk(hold_o == 1'b1, "R5 hold with busy", hold_o, 1);
      if (!busy_o && busy_prev) chk(width == CONV_CYC, "R5 busy width", width, CONV_CYC);
      if (result_stb_o) begin
         chk(busy_prev && !busy_o, "R6 strobe at busy fall", busy_o, 0);
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected result", result_o, 0);
         else begin
            logic [CODE_W-1:0] e;
            e = exp_q.pop_front();
            chk(result_o == e, "R7 result code", result_o, e);
         end
      end
      busy_prev = busy_o;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic launch(input logic [CODE_W-1:0] v, input int hi);
      vin = v;
      exp_q.push_back(v);
      start_i = 1'b1;
      cyc(hi);
      start_i = 1'b0;
   endtask

   task automatic wait_busy(input logic val, output int n);
      n = 0;
      while (busy_o !== val && n < 400) begin cyc(1); n++; end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n, r0, e0, pl;
      cyc(4);
      // R1: reset state
      chk(!busy_o && !hold_o && !pwr_en_o && !pulse_o && !result_stb_o && !err_o,
          "R1 reset outputs", {busy_o, pwr_en_o, pulse_o}, 0);
      chk(result_o == 0, "R1 reset result", result_o, 0);
      rst_n = 1'b1;
      cyc(3);

      // R2: too-short start pulse
      start_i = 1'b1; cyc(MIN_HI_CYC - 1); start_i = 1'b0;
      cyc(30);
      chk(pwr_en_o == 1'b0, "R2 short pulse power", pwr_en_o, 0);
      chk(busy_rises == 0, "R2 short pulse no conversion", busy_rises, 0);

      // short start: power-up pulse ends last (0xA5)
      launch(8'hA5, 4);
      n = 0;
      while (!pulse_o && n < 20) begin cyc(1); n++; end
      chk(pwr_en_o == 1'b1, "R3 power on", pwr_en_o, 1);
      chk(gate_o == 1'b1, "R3 gate is OR", gate_o, 1);
      pl = 0;
      while (pulse_o && pl < 100) begin
         chk(busy_o == 1'b0, "R4 no busy during pulse", busy_o, 0);
         cyc(1); pl++;
      end
      chk(pl == PWRUP_CYC, "R3 pulse length", pl, PWRUP_CYC);
      wait_busy(1'b1, n);
      chk(n <= 4, "R4 start after pulse fall", n, 4);
      wait_busy(1'b0, n);
      cyc(3);
      chk(pwr_en_o == 1'b0, "R8 auto power-down", pwr_en_o, 0);

      // long start: input's own falling edge is later (0x00)
      r0 = busy_rises;
      launch(8'h00, 40);
      chk(busy_rises == r0, "R4 no start while input high", busy_rises, r0);
      wait_busy(1'b1, n);
      chk(n <= 8, "R4 start after input fall", n, 8);
      wait_busy(1'b0, n);
      cyc(3);
      chk(pwr_en_o == 1'b0, "R8 power-down after long pulse", pwr_en_o, 0);

      // all ones (0xFF)
      launch(8'hFF, 5);
      wait_busy(1'b1, n);
      wait_busy(1'b0, n);
      cyc(3);

      // high-speed mode: start re-raised while busy (0x3C then 0x81)
      r0 = busy_rises; e0 = err_seen;
      launch(8'h3C, 5);
      wait_busy(1'b1, n);
      cyc(10);
      start_i = 1'b1;
      wait_busy(1'b0, n);
      cyc(3);
      chk(err_seen == e0 + 1, "R9 error on busy edge", err_seen, e0 + 1);
      chk(busy_rises == r0 + 1, "R9 no restart", busy_rises, r0 + 1);
      chk(pwr_en_o == 1'b1, "R8 stay powered", pwr_en_o, 1);
      chk(pulse_o == 1'b0, "R9 no power-up pulse", pulse_o, 0);
      vin = 8'h81;
      exp_q.push_back(8'h81);
      start_i = 1'b0;
      n = 0;
      while (!busy_o && n < 100) begin
         chk(pulse_o == 1'b0, "R10 no pulse before restart", pulse_o, 0);
         cyc(1); n++;
      end
      chk(n <= 8, "R10 immediate restart", n, 8);
      wait_busy(1'b0, n);
      cyc(3);
      chk(pwr_en_o == 1'b0, "R8 power-down after fast mode", pwr_en_o, 0);
      chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule